// File: doc/BRIEF.md
# Parallel Bus Target Phase Sequencer

This block is the target end of an 8-bit parallel peripheral bus on which an initiator picks a target by putting both IDs on the data lines and raising a select line. Once the block sees its own ID during selection, it claims the bus by raising its busy line. It then moves through four information phases: command, data-in, status and message. Three phase lines (control/data, direction and message) show which phase is running. Every byte, in either direction, is transferred with an interlocked four-edge request/acknowledge handshake.

The only command it carries out is a read, in which bytes stream from a local buffer to the initiator. Any other operation code is accepted and answered with an error status. After the message byte the block releases every line and the bus is free again. If an acknowledge edge does not come within a set number of cycles, the block abandons the connection and returns to bus-free.

Top module: `pbt_target`

## Requirements
- R1: While reset is held and after it is released, busy, request, the three phase lines, data-line enable and buffer pop are all low.
- R2: With select high and incoming busy low, the block raises busy one clock later only when the data lines hold its own ID bit plus exactly one other bit. A pattern without its bit, or with three bits set, leaves busy low.
- R3: Once select falls after a successful selection, the phase lines read control/data=1, direction=0, message=0. In the first command byte, bits [7:4] are the operation code and bits [3:0] give the number of command bytes that follow. The byte after it gives the read length in bytes. Any further command bytes are received and discarded.
- R4: Request rises only after acknowledge has been seen low, and it falls one clock after acknowledge is seen high. The next request waits for acknowledge to go low. The byte on the data lines stays stable while request is high.
- R5: For a read (operation code 1) with a non-zero length, the data-in phase shows control/data=0, direction=1, message=0. It sends exactly that many buffer bytes, in buffer order, with one buffer pop per byte.
- R6: In data-in with the buffer empty, the block stays in that phase with request low until data is available.
- R7: The status phase shows control/data=1, direction=1, message=0 and sends one byte: 0x00 after a read, 0x02 for any other operation code, which skips data-in.
- R8: The message phase shows all three phase lines high and sends 0x00. Once the final acknowledge falls, busy and all phase lines drop on the next clock. No phase line is ever high without busy.
- R9: If request stays high for TIMEOUT_CYC cycles without acknowledge, or acknowledge stays high that long after request falls, the block releases all lines and returns to bus-free. It can be selected again afterwards.
- R10: A read with length 0 goes from command straight to status and sends 0x00.
- R11: The data-line enable is high only in the phases where bytes flow from target to initiator (direction line high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsy_i | input | 1 | Busy line as seen on the bus |
| sel_i | input | 1 | Select line from the initiator |
| ack_i | input | 1 | Acknowledge from the initiator |
| db_i | input | DATA_W | Data lines as seen on the bus |
| bsy_o | output | 1 | Busy driven by this target |
| req_o | output | 1 | Request driven by this target |
| cd_o | output | 1 | Phase line: control (1) or data (0) |
| io_o | output | 1 | Phase line: direction, 1 = target to initiator |
| msg_o | output | 1 | Phase line: message phase |
| db_o | output | DATA_W | Byte driven onto the data lines |
| db_oe_o | output | 1 | Enable for the data line drivers |
| buf_valid_i | input | 1 | Local buffer holds a byte |
| buf_data_i | input | DATA_W | Byte at the buffer head |
| buf_pop_o | output | 1 | Consumes the buffer head |
| cmd_op_o | output | 4 | Captured operation code |
| xfer_len_o | output | DATA_W | Captured read length |

## Verification
The bench builds the block with an 8-bit bus, target ID 3, strict two-ID selection and a 16-cycle timeout. The short timeout means the abandon-and-recover path is reached in a few dozen cycles, and strict selection makes the three-bit rejection case reachable. The bench's initiator model runs complete reads of several lengths, a zero-length read, an unsupported operation and a starved buffer. It checks every byte and phase against a queue of expected buffer contents.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

   typedef enum logic [2:0] {
      PH_FREE,
      PH_SELECTED,
      PH_COMMAND,
      PH_DATA_IN,
      PH_STATUS,
      PH_MESSAGE
   } phase_e;

   typedef enum logic [1:0] {
      HS_IDLE,
      HS_SETUP,
      HS_REQ,
      HS_RELEASE
   } hs_e;

   typedef struct packed {
      logic cd;
      logic io;
      logic msg;
   } phase_lines_t;

   function automatic phase_lines_t lines_of(phase_e p);
      phase_lines_t l;
      l = '0;
      case (p)
         PH_COMMAND: l = '{cd: 1'b1, io: 1'b0, msg: 1'b0};
         PH_DATA_IN: l = '{cd: 1'b0, io: 1'b1, msg: 1'b0};
         PH_STATUS:  l = '{cd: 1'b1, io: 1'b1, msg: 1'b0};
         PH_MESSAGE: l = '{cd: 1'b1, io: 1'b1, msg: 1'b1};
         default:    l = '0;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/pbt_sel_detect.sv
module pbt_sel_detect #(
   parameter int DATA_W     = 8,
   parameter int TARGET_ID  = 3,
   parameter bit STRICT_SEL = 1'b1
) (
   input  logic              sel_i,
   input  logic              bsy_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              hit_o
);
   localparam logic [DATA_W-1:0] OWN_MASK = DATA_W'(1) << TARGET_ID;

   logic own_bit;
   logic ids_ok;

   assign own_bit = db_i[TARGET_ID];

   generate
      if (STRICT_SEL) begin : g_strict
         // own ID plus exactly one initiator ID
         assign ids_ok = ($countones(db_i) == 2);
      end else begin : g_relaxed
         // own ID plus at least one other ID
         assign ids_ok = |(db_i & ~OWN_MASK);
      end
   endgenerate

   assign hit_o = sel_i & ~bsy_i & own_bit & ids_ok;

endmodule

// File: rtl/pbt_handshake.sv
module pbt_handshake
   import pbt_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic ready_i,
   input  logic ack_i,
   output logic req_o,
   output logic load_o,
   output logic capture_o,
   output logic done_o,
   output logic timeout_o
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

   hs_e              st_q, st_d;
   logic [CNT_W-1:0] wait_q;
   logic             expire;

   assign expire = (wait_q == LAST);

   always_comb begin
      st_d      = st_q;
      load_o    = 1'b0;
      capture_o = 1'b0;
      done_o    = 1'b0;
      timeout_o = 1'b0;
      case (st_q)
         HS_IDLE: begin
            if (go_i && ready_i && !ack_i) begin
               load_o = 1'b1;
               st_d   = HS_SETUP;
            end
         end
         HS_SETUP: begin
            if (!ack_i) st_d = HS_REQ;
         end
         HS_REQ: begin
            if (ack_i) begin
               capture_o = 1'b1;
               st_d      = HS_RELEASE;
            end else if (expire) begin
               timeout_o = 1'b1;
               st_d      = HS_IDLE;
            end
         end
         HS_RELEASE: begin
            if (!ack_i) begin
               done_o = 1'b1;
               st_d   = HS_IDLE;
            end else if (expire) begin
               timeout_o = 1'b1;
               st_d      = HS_IDLE;
            end
         end
         default: st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= HS_IDLE;
         wait_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d != st_q || st_q == HS_IDLE || st_q == HS_SETUP)
            wait_q <= '0;
         else
            wait_q <= wait_q + 1'b1;
      end
   end

   assign req_o = (st_q == HS_REQ);

endmodule

// File: rtl/pbt_phase_ctrl.sv
module pbt_phase_ctrl
   import pbt_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               OP_W        = 4,
   parameter int               CNT_FIELD_W = 4,
   parameter logic [OP_W-1:0]  READ_OP     = 4'h1,
   parameter logic [DATA_W-1:0] GOOD_STAT  = 8'h00,
   parameter logic [DATA_W-1:0] BAD_STAT   = 8'h02,
   parameter logic [DATA_W-1:0] DONE_MSG   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_hit_i,
   input  logic              sel_i,
   input  logic [DATA_W-1:0] db_i,
   input  logic              buf_valid_i,
   input  logic [DATA_W-1:0] buf_data_i,
   input  logic              load_i,
   input  logic              capture_i,
   input  logic              done_i,
   input  logic              timeout_i,
   output phase_e            phase_o,
   output logic              go_o,
   output logic              ready_o,
   output logic [DATA_W-1:0] dout_o,
   output logic              buf_pop_o,
   output logic [OP_W-1:0]   cmd_op_o,
   output logic [DATA_W-1:0] xfer_len_o
);
   phase_e                 phase_q;
   logic                   first_q;
   logic                   second_q;
   logic [CNT_FIELD_W-1:0] remain_q;
   logic [OP_W-1:0]        op_q;
   logic [DATA_W-1:0]      len_q;
   logic [DATA_W-1:0]      left_q;
   logic [DATA_W-1:0]      out_byte;
   logic                   is_read;

   assign is_read = (op_q == READ_OP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_FREE;
         first_q  <= 1'b0;
         second_q <= 1'b0;
         remain_q <= '0;
         op_q     <= '0;
         len_q    <= '0;
         left_q   <= '0;
      end else if (timeout_i) begin
         phase_q <= PH_FREE;
      end else begin
         case (phase_q)
            PH_FREE: begin
               if (sel_hit_i) phase_q <= PH_SELECTED;
            end
            PH_SELECTED: begin
               if (!sel_i) begin
                  phase_q  <= PH_COMMAND;
                  first_q  <= 1'b1;
                  second_q <= 1'b0;
                  len_q    <= '0;
               end
            end
            PH_COMMAND: begin
               if (capture_i) begin
                  if (first_q) begin
                     op_q     <= db_i[DATA_W-1 -: OP_W];
                     remain_q <= db_i[CNT_FIELD_W-1:0];
                     first_q  <= 1'b0;
                     second_q <= 1'b1;
                  end else begin
                     if (second_q) len_q <= db_i;
                     second_q <= 1'b0;
                     remain_q <= remain_q - 1'b1;
                  end
               end
               if (done_i && !first_q && remain_q == '0) begin
                  if (is_read && len_q != '0) begin
                     phase_q <= PH_DATA_IN;
                     left_q  <= len_q;
                  end else begin
                     phase_q <= PH_STATUS;
                  end
               end
            end
            PH_DATA_IN: begin
               if (done_i) begin
                  left_q <= left_q - 1'b1;
                  if (left_q == DATA_W'(1)) phase_q <= PH_STATUS;
               end
            end
            PH_STATUS: begin
               if (done_i) phase_q <= PH_MESSAGE;
            end
            PH_MESSAGE: begin
               if (done_i) phase_q <= PH_FREE;
            end
            default: phase_q <= PH_FREE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_DATA_IN: out_byte = buf_data_i;
         PH_STATUS:  out_byte = is_read ? GOOD_STAT : BAD_STAT;
         PH_MESSAGE: out_byte = DONE_MSG;
         default:    out_byte = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      dout_o <= '0;
      else if (load_i) dout_o <= out_byte;
   end

   assign go_o       = (phase_q == PH_COMMAND) || (phase_q == PH_DATA_IN) ||
                       (phase_q == PH_STATUS)  || (phase_q == PH_MESSAGE);
   assign ready_o    = (phase_q == PH_DATA_IN) ? buf_valid_i : 1'b1;
   assign buf_pop_o  = load_i && (phase_q == PH_DATA_IN);
   assign phase_o    = phase_q;
   assign cmd_op_o   = op_q;
   assign xfer_len_o = len_q;

endmodule

// File: rtl/pbt_target.sv
module pbt_target
   import pbt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TARGET_ID   = 3,
   parameter int TIMEOUT_CYC = 1024,
   parameter bit STRICT_SEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsy_i,
   input  logic              sel_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              bsy_o,
   output logic              req_o,
   output logic              cd_o,
   output logic              io_o,
   output logic              msg_o,
   output logic [DATA_W-1:0] db_o,
   output logic              db_oe_o,
   input  logic              buf_valid_i,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic              buf_pop_o,
   output logic [3:0]        cmd_op_o,
   output logic [DATA_W-1:0] xfer_len_o
);
   localparam int OP_W        = 4;
   localparam int CNT_FIELD_W = 4;

   generate
      if (TARGET_ID < 0 || TARGET_ID >= DATA_W) begin : g_bad_id
         $error("pbt_target: TARGET_ID outside data bus");
      end
      if (OP_W + CNT_FIELD_W > DATA_W) begin : g_bad_width
         $error("pbt_target: DATA_W too narrow for command fields");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("pbt_target: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic              sel_hit;
   logic              go, ready, load, capture, done, timeout;
   logic [DATA_W-1:0] dout;
   phase_e            phase;
   phase_lines_t      lines;

   pbt_sel_detect #(
      .DATA_W    (DATA_W),
      .TARGET_ID (TARGET_ID),
      .STRICT_SEL(STRICT_SEL)
   ) u_sel (
      .sel_i(sel_i),
      .bsy_i(bsy_i),
      .db_i (db_i),
      .hit_o(sel_hit)
   );

   pbt_handshake #(
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .ready_i  (ready),
      .ack_i    (ack_i),
      .req_o    (req_o),
      .load_o   (load),
      .capture_o(capture),
      .done_o   (done),
      .timeout_o(timeout)
   );

   pbt_phase_ctrl #(
      .DATA_W     (DATA_W),
      .OP_W       (OP_W),
      .CNT_FIELD_W(CNT_FIELD_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_hit_i  (sel_hit),
      .sel_i      (sel_i),
      .db_i       (db_i),
      .buf_valid_i(buf_valid_i),
      .buf_data_i (buf_data_i),
      .load_i     (load),
      .capture_i  (capture),
      .done_i     (done),
      .timeout_i  (timeout),
      .phase_o    (phase),
      .go_o       (go),
      .ready_o    (ready),
      .dout_o     (dout),
      .buf_pop_o  (buf_pop_o),
      .cmd_op_o   (cmd_op_o),
      .xfer_len_o (xfer_len_o)
   );

   assign lines   = lines_of(phase);
   assign bsy_o   = (phase != PH_FREE);
   assign cd_o    = lines.cd;
   assign io_o    = lines.io;
   assign msg_o   = lines.msg;
   assign db_oe_o = lines.io;
   assign db_o    = lines.io ? dout : '0;

endmodule

// File: rtl/pbt_target_chk.sv
module pbt_target_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic              ack_i,
   input logic              bsy_o,
   input logic              req_o,
   input logic              cd_o,
   input logic              io_o,
   input logic              msg_o,
   input logic [DATA_W-1:0] db_o,
   input logic              db_oe_o,
   input logic              buf_valid_i,
   input logic              buf_pop_o
);
   AST_REQ_WITH_BSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> bsy_o); // R4
   AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> !$past(ack_i)); // R4
   AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i) |=> !req_o); // R4
   AST_DB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && $past(req_o)) |-> $stable(db_o)); // R4
   AST_LINES_NEED_BSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_o || io_o || msg_o) |-> bsy_o); // R8
   AST_MSG_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
      msg_o |-> (cd_o && io_o)); // R8
   AST_OE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe_o |-> io_o); // R11
   AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop_o |-> (buf_valid_i && io_o && !cd_o && !req_o)); // R6
   AST_BSY_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bsy_o) |-> $past(sel_i)); // R2
endmodule

bind pbt_target pbt_target_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_i      (sel_i),
   .ack_i      (ack_i),
   .bsy_o      (bsy_o),
   .req_o      (req_o),
   .cd_o       (cd_o),
   .io_o       (io_o),
   .msg_o      (msg_o),
   .db_o       (db_o),
   .db_oe_o    (db_oe_o),
   .buf_valid_i(buf_valid_i),
   .buf_pop_o  (buf_pop_o)
);

// File: tb/pbt_target_test.sv
module pbt_target_test;
   localparam int DW  = 8;
   localparam int TID = 3;
   localparam int TMO = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          bsy_i = 1'b0, sel_i = 1'b0, ack_i = 1'b0;
   logic [DW-1:0] db_i = '0;
   logic          bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_pop_o;
   logic [DW-1:0] db_o, xfer_len_o;
   logic [3:0]    cmd_op_o;
   logic          buf_valid_i = 1'b0;
   logic [DW-1:0] buf_data_i = '0;

   logic [DW-1:0] bufq[$];
   bit            pop_pending = 1'b0;
   int            n_chk = 0, n_fail = 0, cyc = 0;

   pbt_target #(
      .DATA_W(DW), .TARGET_ID(TID), .TIMEOUT_CYC(TMO), .STRICT_SEL(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bsy_i(bsy_i), .sel_i(sel_i), .ack_i(ack_i),
      .db_i(db_i), .bsy_o(bsy_o), .req_o(req_o), .cd_o(cd_o), .io_o(io_o),
      .msg_o(msg_o), .db_o(db_o), .db_oe_o(db_oe_o), .buf_valid_i(buf_valid_i),
      .buf_data_i(buf_data_i), .buf_pop_o(buf_pop_o), .cmd_op_o(cmd_op_o),
      .xfer_len_o(xfer_len_o)
   );

   task automatic check_eq(input string rq, input string what,
                           input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic void refresh();
      buf_valid_i = (bufq.size() != 0);
      buf_data_i  = (bufq.size() != 0) ? bufq[0] : '0;
   endfunction

   // buffer model: a pop seen before an edge takes effect after that edge
   always @(negedge clk) begin
      #2;
      cyc++;
      pop_pending = buf_pop_o;
      check_eq("R4", "request without busy", {req_o, bsy_o} == 2'b10, 0);
      if (cyc > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   always @(posedge clk) begin
      #1;
      if (pop_pending && bufq.size() != 0) void'(bufq.pop_front());
      pop_pending = 1'b0;
      refresh();
   end

   task automatic do_select(input logic [DW-1:0] ids, input bit hit);
      @(negedge clk);
      db_i  = ids;
      sel_i = 1'b1;
      @(negedge clk);
      check_eq("R2", "busy after select", bsy_o, hit);
      if (hit) begin
         sel_i = 1'b0;
         db_i  = '0;
         @(negedge clk);
         check_eq("R3", "command phase lines", {cd_o, io_o, msg_o}, 3'b100);
      end else begin
         repeat (2) @(negedge clk);
         check_eq("R2", "busy stays low", bsy_o, 1'b0);
         sel_i = 1'b0;
         db_i  = '0;
         @(negedge clk);
      end
   endtask

   task automatic do_byte(input string rq, input logic [2:0] lines,
                          input logic [DW-1:0] send, input logic [DW-1:0] exp_byte);
      int w;
      w = 0;
      while (!req_o && w < 200) begin
         @(negedge clk);
         w++;
      end
      check_eq(rq, "request seen", req_o, 1'b1);
      check_eq(rq, "phase lines cd/io/msg", {cd_o, io_o, msg_o}, lines);
      check_eq("R11", "driver enable", db_oe_o, lines[1]);
      if (lines[1]) check_eq(rq, "byte to initiator", db_o, exp_byte);
      db_i  = send;
      ack_i = 1'b1;
      @(negedge clk);
      check_eq("R4", "request low one cycle after ack", req_o, 1'b0);
      ack_i = 1'b0;
      db_i  = '0;
      @(negedge clk);
   endtask

   task automatic finish_seq(input logic [DW-1:0] status);
      do_byte("R7", 3'b110, '0, status);
      do_byte("R8", 3'b111, '0, 8'h00);
      check_eq("R8", "busy and lines released", {bsy_o, cd_o, io_o, msg_o, req_o}, 5'b0);
   endtask

   initial begin
      logic [DW-1:0] exp_data[4];
      exp_data = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
      repeat (3) @(negedge clk);
      check_eq("R1", "outputs in reset", {bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_pop_o}, 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "outputs after reset", {bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_pop_o}, 7'b0);

      // R2: own bit missing, then three IDs present
      do_select(8'h84, 1'b0);
      do_select(8'h8A, 1'b0);

      // R3 R5: read of four bytes, with one extra ignored command byte
      foreach (exp_data[i]) bufq.push_back(exp_data[i]);
      refresh();
      do_select(8'h88, 1'b1);
      do_byte("R3", 3'b100, 8'h12, '0);
      do_byte("R3", 3'b100, 8'h04, '0);
      do_byte("R3", 3'b100, 8'h5A, '0);
      check_eq("R3", "captured opcode", cmd_op_o, 4'h1);
      check_eq("R3", "captured length", xfer_len_o, 8'h04);
      for (int i = 0; i < 4; i++) do_byte("R5", 3'b010, '0, exp_data[i]);
      finish_seq(8'h00);
      check_eq("R5", "buffer entries consumed", bufq.size(), 0);

      // R9: no acknowledge for the first command byte
      do_select(8'h88, 1'b1);
      while (!req_o) @(negedge clk);
      repeat (TMO - 2) @(negedge clk);
      check_eq("R9", "request still high before limit", req_o, 1'b1);
      repeat (2) @(negedge clk);
      check_eq("R9", "released after timeout", {bsy_o, req_o, cd_o, io_o, msg_o}, 5'b0);

      // R7: unsupported opcode, also shows recovery after timeout
      do_select(8'h88, 1'b1);
      do_byte("R7", 3'b100, 8'h20, '0);
      finish_seq(8'h02);

      // R10: read of length zero
      do_select(8'h88, 1'b1);
      do_byte("R10", 3'b100, 8'h11, '0);
      do_byte("R10", 3'b100, 8'h00, '0);
      finish_seq(8'h00);

      // R6: buffer starts empty
      do_select(8'h88, 1'b1);
      do_byte("R6", 3'b100, 8'h11, '0);
      do_byte("R6", 3'b100, 8'h03, '0);
      repeat (12) begin
         @(negedge clk);
         check_eq("R6", "request held low while empty", req_o, 1'b0);
         check_eq("R6", "stays in data phase", {cd_o, io_o, msg_o}, 3'b010);
      end
      bufq.push_back(8'h3C);
      bufq.push_back(8'h7E);
      bufq.push_back(8'h00);
      refresh();
      do_byte("R6", 3'b010, '0, 8'h3C);
      do_byte("R5", 3'b010, '0, 8'h7E);
      do_byte("R5", 3'b010, '0, 8'h00);
      finish_seq(8'h00);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule